// File: doc/BRIEF.md
# Capture/Compare Channel Status Flags

This block is one channel group of a general-purpose timer. It has a single free-running up-counter and three general registers, named A, B and C. Each general register works in one of two modes. In capture mode it takes a copy of the counter when an external event arrives. In compare mode it holds a value that is checked against the counter. Each register has a status flag that records a capture or a compare match. Software reads these flags through a small register bus.

To clear a flag, software must first read it while it is 1 and then write 0 to it. A stray write of 0, or a write that was not preceded by a matching read, cannot lose an event. The counter advances on a one-cycle enable, `cnt_tick`, which comes from a prescaler outside this block. The capture inputs may be asynchronous. Each one passes through a two-stage synchronizer and then a rising-edge detector.

Top module: `tcs_timer_flags`

## Requirements
- R1: A synchronous active-high reset clears the counter, the three general registers, the mode bits, the status flags, the read arms and the read-data register to 0.
- R2: A register in compare mode (mode bit 0) sets its flag once its value equals the counter, in the cycle after the counter has stepped onto that value.
- R3: A register in capture mode (mode bit 1) takes the counter value and sets its flag when its capture input rises. The rise is seen two clock edges after it crosses the synchronizer, and the load and the flag update happen one edge later.
- R4: Writing 0 to a flag that has not been read as 1 since the last status write leaves that flag set.
- R5: A flag that was read as 1 and then has 0 written to it on the next status write is cleared.
- R6: Writing 1 to a status bit never changes that flag, so software cannot set a flag.
- R7: A status read arms only the flags that were 1 at that read. Any status write uses up every arm, whatever value it writes.
- R8: If a set event and a valid clearing write fall in the same cycle, the flag stays 1.
- R9: A compare match is evaluated only once per counter increment. While the counter is halted on a matching value, a cleared flag stays 0. After a full wrap of the counter, the flag sets again.
- R10: A register in compare mode ignores edges on its capture input: neither its value nor its flag changes. A register in capture mode never flags on counter equality.
- R11: The bus address map is: 0 for status, 1 for mode, 2 for register A, 3 for register B, 4 for register C and 5 for the counter (read only). In the status and mode words, bit 0 belongs to A, bit 1 to B and bit 2 to C.
- R12: All three registers compare against, or capture from, the same counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data, valid the cycle after a read |
| cnt_tick | input | 1 | Counter advance enable |
| cap_in | input | 3 | Capture event inputs (bit 0 for A, bit 1 for B, bit 2 for C), may be asynchronous |
| status_flags | output | 3 | Registered copy of the status flags |

## Verification
The hardest condition to reach is a new set event that lands in exactly the cycle of an armed clearing write. The bench arranges this with a capture input. It raises the input on a falling edge, waits two clock edges through the synchronizer, and then drives the clearing write so that the write and the detected edge are sampled on the same rising edge. The re-arming of a compare after a full counter wrap is reached by running the counter with a narrow width. A cleared flag is then held at a halted matching count to show that no second event occurs.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int unsigned NUM_GR = 3;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STAT = 3'd0,
    ADR_MODE = 3'd1,
    ADR_GRA  = 3'd2,
    ADR_GRB  = 3'd3,
    ADR_GRC  = 3'd4,
    ADR_CNT  = 3'd5
  } tcs_addr_e;
endpackage

// File: rtl/tcs_sync_edge.sv
module tcs_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tcs_counter.sv
module tcs_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         stepped
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      stepped <= 1'b0;
    end else begin
      stepped <= tick;
      if (tick) cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/tcs_channel.sv
module tcs_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture_mode,
  input  logic         cap_rise,
  input  logic [W-1:0] cnt,
  input  logic         stepped,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] gr,
  output logic         cap_evt,
  output logic         set_evt
);
  logic cmp_evt;

  assign cap_evt = capture_mode & cap_rise;
  // equality is only meaningful on the cycle right after an increment
  assign cmp_evt = ~capture_mode & stepped & (cnt == gr);
  assign set_evt = cap_evt | cmp_evt;

  always_ff @(posedge clk) begin
    if (rst)          gr <= '0;
    else if (cap_evt) gr <= cnt;
    else if (wr_en)   gr <= wdata;
  end
endmodule

// File: rtl/tcs_status.sv
module tcs_status #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic         rd_stat,
  input  logic         wr_stat,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] arm
);
  logic [N-1:0] clr;

  assign clr = wr_stat ? (arm & ~wdata) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      arm   <= '0;
    end else begin
      if (wr_stat)      arm <= '0;
      else if (rd_stat) arm <= arm | flags;
      // set events override clearing in the same cycle
      flags <= (flags & ~clr) | set_evt;
    end
  end
endmodule

// File: rtl/tcs_timer_flags.sv
module tcs_timer_flags
  import tcs_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cnt_tick,
  input  logic [NUM_GR-1:0] cap_in,
  output logic [NUM_GR-1:0] status_flags
);
  logic [CNT_W-1:0]             cnt_q;
  logic                         stepped;
  logic [NUM_GR-1:0]            mode_q;
  logic [NUM_GR-1:0]            cap_rise;
  logic [NUM_GR-1:0]            cap_evt;
  logic [NUM_GR-1:0]            set_evt;
  logic [NUM_GR-1:0]            arm_q;
  logic [NUM_GR-1:0][CNT_W-1:0] gr;
  logic                         rd_acc, wr_acc, rd_stat, wr_stat;

  assign rd_acc  = bus_sel & ~bus_wr;
  assign wr_acc  = bus_sel & bus_wr;
  assign rd_stat = rd_acc & (bus_addr == ADR_STAT);
  assign wr_stat = wr_acc & (bus_addr == ADR_STAT);

  tcs_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(cnt_tick), .cnt(cnt_q), .stepped(stepped)
  );

  for (genvar i = 0; i < NUM_GR; i++) begin : g_ch
    logic gr_wr;
    assign gr_wr = wr_acc & (bus_addr == ADDR_W'(ADR_GRA + i));

    tcs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(cap_in[i]), .rise(cap_rise[i])
    );

    tcs_channel #(.W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .capture_mode(mode_q[i]), .cap_rise(cap_rise[i]),
      .cnt(cnt_q), .stepped(stepped), .wr_en(gr_wr), .wdata(bus_wdata),
      .gr(gr[i]), .cap_evt(cap_evt[i]), .set_evt(set_evt[i])
    );
  end

  tcs_status #(.N(NUM_GR)) u_stat (
    .clk(clk), .rst(rst), .set_evt(set_evt), .rd_stat(rd_stat),
    .wr_stat(wr_stat), .wdata(bus_wdata[NUM_GR-1:0]),
    .flags(status_flags), .arm(arm_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_acc && bus_addr == ADR_MODE) mode_q <= bus_wdata[NUM_GR-1:0];
      if (rd_acc) begin
        case (bus_addr)
          ADR_STAT: bus_rdata <= CNT_W'(status_flags);
          ADR_MODE: bus_rdata <= CNT_W'(mode_q);
          ADR_GRA:  bus_rdata <= gr[0];
          ADR_GRB:  bus_rdata <= gr[1];
          ADR_GRC:  bus_rdata <= gr[2];
          ADR_CNT:  bus_rdata <= cnt_q;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [N-1:0]      flags,
  input logic [N-1:0]      arm,
  input logic [N-1:0]      set_evt,
  input logic [N-1:0]      cap_evt,
  input logic [W-1:0]      cnt,
  input logic [N-1:0][W-1:0] gr
);
  logic stat_rd, stat_wr;
  assign stat_rd = bus_sel && !bus_wr && bus_addr == 3'd0;
  assign stat_wr = bus_sel && bus_wr && bus_addr == 3'd0;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_RISE_HAS_EVENT: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[i]) |-> $past(set_evt[i])); // R6
    AST_FLAG_FALL_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[i]) |-> $past(stat_wr && arm[i] && !bus_wdata[i])); // R5
    AST_EVENT_WINS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> flags[i]); // R8
    AST_ARM_ONLY_ON_SET_READ: assert property (@(posedge clk) disable iff (rst)
      $rose(arm[i]) |-> $past(stat_rd && flags[i])); // R7
    AST_CAPTURE_LOADS_COUNT: assert property (@(posedge clk) disable iff (rst)
      cap_evt[i] |=> gr[i] == $past(cnt)); // R3
  end
endmodule

bind tcs_timer_flags tcs_checker #(.W(CNT_W), .N(tcs_pkg::NUM_GR)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags(status_flags),
  .arm(arm_q), .set_evt(set_evt), .cap_evt(cap_evt), .cnt(cnt_q), .gr(gr)
);

// File: tb/test_tcs_timer_flags.sv
module test_tcs_timer_flags;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         cnt_tick = 1'b0;
  logic [2:0]   cap_in = '0;
  logic [2:0]   status_flags;

  int checks = 0, errors = 0, cycles = 0;
  logic [W-1:0] rd_val;

  always #2.5 clk = ~clk;

  tcs_timer_flags #(.CNT_W(W)) i_tcs_timer_flags (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .cap_in(cap_in), .status_flags(status_flags)
  );

  // behavioural reference model
  logic [W-1:0] m_cnt, m_rdata;
  logic         m_stepped;
  logic [2:0]   m_flags, m_arm, m_mode, m_set, m_capv, m_clr;
  logic [W-1:0] m_gr [3];
  logic [2:0]   m_hist [3];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_rdata = '0; m_stepped = 0; m_flags = '0; m_arm = '0; m_mode = '0;
      for (int i = 0; i < 3; i++) begin m_gr[i] = '0; m_hist[i] = '0; end
    end else begin
      for (int i = 0; i < 3; i++) begin
        m_capv[i] = m_mode[i] && m_hist[i][1] && !m_hist[i][2];
        m_set[i]  = m_capv[i] || (!m_mode[i] && m_stepped && m_cnt == m_gr[i]);
      end
      if (bus_sel && !bus_wr) begin
        if (bus_addr == 0)      m_rdata = W'(m_flags);
        else if (bus_addr == 1) m_rdata = W'(m_mode);
        else if (bus_addr <= 4) m_rdata = m_gr[bus_addr-2];
        else if (bus_addr == 5) m_rdata = m_cnt;
        else                    m_rdata = '0;
        if (bus_addr == 0) m_arm = m_arm | m_flags;
      end
      m_clr = '0;
      if (bus_sel && bus_wr && bus_addr == 0) begin
        m_clr = m_arm & ~bus_wdata[2:0];
        m_arm = '0;
      end
      for (int i = 0; i < 3; i++) begin
        if (m_capv[i]) m_gr[i] = m_cnt;
        else if (bus_sel && bus_wr && bus_addr == 3'(i + 2)) m_gr[i] = bus_wdata;
      end
      if (bus_sel && bus_wr && bus_addr == 1) m_mode = bus_wdata[2:0];
      m_flags = (m_flags & ~m_clr) | m_set;
      m_stepped = cnt_tick;
      if (cnt_tick) m_cnt = m_cnt + 1'b1;
      for (int i = 0; i < 3; i++) m_hist[i] = {m_hist[i][1:0], cap_in[i]};
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (status_flags !== m_flags || bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R2/R3/R5/R8 model mismatch at cycle %0d: flags %b rdata %0d, expected flags %b rdata %0d",
                 cycles, status_flags, bus_rdata, m_flags, m_rdata);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [W-1:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic run(input int n);
    cnt_tick = 1;
    repeat (n) @(negedge clk);
    cnt_tick = 0;
    idle(2);
  endtask

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    chk("R1 flags after reset", W'(status_flags), 0);
    do_rd(3'd0, rd_val); chk("R1 status read after reset", rd_val, 0);
    do_rd(3'd5, rd_val); chk("R1 counter after reset", rd_val, 0);

    do_wr(3'd2, 10); do_wr(3'd3, 20); do_wr(3'd4, 30);
    run(15); chk("R2 R11 compare A sets bit 0", W'(status_flags), 3'b001);
    run(10); chk("R12 compare B on shared counter", W'(status_flags), 3'b011);
    run(10); chk("R12 R11 compare C sets bit 2", W'(status_flags), 3'b111);

    do_wr(3'd0, 0); idle(1);
    chk("R4 write 0 without read keeps flags", W'(status_flags), 3'b111);
    do_rd(3'd0, rd_val); chk("R11 status read", rd_val, 3'b111);
    do_wr(3'd0, 3'b110); idle(1);
    chk("R5 R6 clear A only, ones ignored", W'(status_flags), 3'b110);
    do_wr(3'd0, 0); idle(1);
    chk("R7 arms used by previous write", W'(status_flags), 3'b110);
    do_rd(3'd0, rd_val); do_wr(3'd0, 0); idle(1);
    chk("R5 read then write 0 clears", W'(status_flags), 0);
    do_wr(3'd0, 3'b111); idle(1);
    chk("R6 writing ones cannot set", W'(status_flags), 0);

    do_wr(3'd2, 36); do_wr(3'd3, 38);
    run(2); chk("R2 A flagged at 36", W'(status_flags), 3'b001);
    do_rd(3'd0, rd_val);
    run(1); chk("R2 B flagged at 38", W'(status_flags), 3'b011);
    do_wr(3'd0, 0); idle(1);
    chk("R7 only flag set at read is cleared", W'(status_flags), 3'b010);
    do_rd(3'd0, rd_val); do_wr(3'd0, 0); idle(1);

    idle(6);
    chk("R9 halted on match gives no new event", W'(status_flags), 0);
    run(256);
    chk("R9 flags rise again after wrap", W'(status_flags), 3'b111);
    do_rd(3'd0, rd_val); do_wr(3'd0, 0); idle(1);

    do_wr(3'd1, 3'b100);
    cap_in[2] = 1; idle(4); cap_in[2] = 0; idle(2);
    chk("R3 capture sets flag C", W'(status_flags), 3'b100);
    do_rd(3'd4, rd_val); chk("R3 capture loads counter into C", rd_val, 38);

    do_rd(3'd0, rd_val);
    run(2);
    cap_in[2] = 1; idle(2);
    do_wr(3'd0, 0);
    chk("R8 event beats armed clear", W'(status_flags), 3'b100);
    cap_in[2] = 0; idle(3);
    do_rd(3'd4, rd_val); chk("R3 second capture value", rd_val, 40);
    do_rd(3'd0, rd_val); do_wr(3'd0, 0); idle(1);
    chk("R5 clear after capture", W'(status_flags), 0);

    cap_in[0] = 1; idle(4); cap_in[0] = 0; idle(3);
    chk("R10 compare channel ignores capture flag", W'(status_flags), 0);
    do_rd(3'd2, rd_val); chk("R10 compare channel value kept", rd_val, 36);
    run(256);
    chk("R10 capture channel ignores equality", W'(status_flags), 3'b011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule